// File: doc/BRIEF.md
# Clock Source Switch Controller

This block decides which of two oscillators paces the system: an internal oscillator that is always available, or a primary oscillator that can be followed by an optional PLL. Both oscillators are modelled as single-cycle enable pulses (`int_tick`, `prim_tick`) on one fast fabric clock. The block turns these pulses into a system clock enable `sys_ce`. It also drives the enable lines of both oscillators, shows which source is in use, and raises a ready flag once the primary source has been handed the system.

A 2-bit source-select register is written through `cfg_wr`. When bit 1 of the value is 1 (codes 2'b10 and 2'b11), the internal-oscillator run mode is chosen. In that mode the primary oscillator is switched off in the next cycle. When bit 1 is 0 (codes 2'b00 and 2'b01), the primary source is requested. The system then keeps running from the internal oscillator while a start-up timer counts primary pulses. If `pll_en` is set, a PLL settle counter of internal pulses follows. The handover itself waits for an internal pulse, so the switch falls on a cycle boundary of the outgoing clock. The ready flag therefore shows the source actually in use, which can lag behind the requested one.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset, `src_sel` = 2'b00, `idle_en` = 0, `osc_ready` = 0, `sel_internal` = 1, `prim_osc_en` = 1 and `int_osc_en` = 1, with the primary start-up sequence running.
- R2: A write whose value has bit 1 set and differs from `src_sel` gives, from the next cycle on, `prim_osc_en` = 0, `osc_ready` = 0 and `sel_internal` = 1. This holds from any state.
- R3: While primary start-up is in progress, `sel_internal` stays 1 and `osc_ready` stays 0 until exactly OST_CYCLES primary pulses have arrived since the sequence began.
- R4: With `pll_en` = 1, a further PLL_TICKS internal pulses must follow the last counted primary pulse before the handover can start. With `pll_en` = 0, this stage is skipped.
- R5: Once qualification is complete, the handover takes place on the next internal pulse. In the cycle after that pulse, `sel_internal` = 0 and `osc_ready` = 1.
- R6: `src_sel` and `idle_en` change only on a `cfg_wr` cycle, where they take `cfg_src` and `cfg_idle`. The switching sequence never alters them.
- R7: `int_osc_en` is 0 only while running from the primary source with both `wdt_en` and `fscm_en` at 0.
- R8: A write that changes `src_sel` to another primary code during start-up clears both counters and restarts the full sequence. A write to an internal code aborts to internal mode.
- R9: A write that leaves the source class unchanged while running (for example primary to primary while `osc_ready` = 1, or writing the current value) does not disturb the clock or the flags.
- R10: `sys_ce` equals `int_tick` while `sel_internal` = 1. Otherwise it equals `prim_tick` gated by `prim_osc_en`. It never pulses without a source pulse in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the select register |
| cfg_src | input | 2 | Source-select value to write |
| cfg_idle | input | 1 | Idle-enable value to write |
| pll_en | input | 1 | PLL in the primary path |
| wdt_en | input | 1 | Watchdog enabled (holds internal oscillator on) |
| fscm_en | input | 1 | Fail-safe monitor enabled (holds internal oscillator on) |
| int_tick | input | 1 | Internal oscillator cycle pulse |
| prim_tick | input | 1 | Primary oscillator cycle pulse |
| src_sel | output | 2 | Current source-select register |
| idle_en | output | 1 | Current idle-enable bit |
| prim_osc_en | output | 1 | Primary oscillator enable |
| int_osc_en | output | 1 | Internal oscillator enable |
| sel_internal | output | 1 | System is paced by the internal source |
| osc_ready | output | 1 | Primary source qualified and in use |
| sys_ce | output | 1 | System clock enable pulse |

## Verification
The start-up sequence is swept across every combination of primary pulse spacing (1 to 3 cycles), internal pulse spacing (1 to 3 cycles) and PLL on or off. The phases of the two pulse trains are offset, so that primary pulses can land in the handover cycle. These runs show whether the counter counts primary rather than internal pulses, whether the PLL stage is added or skipped, and whether the handover waits for an internal pulse instead of switching as soon as qualification ends. Further writes made mid-count, in the PLL stage and while running on the primary source show the difference between a restart, an abort and a harmless rewrite. A sweep over the watchdog and monitor enables shows when the internal oscillator may stop.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [2:0] {
    ST_INT  = 3'd0,
    ST_OST  = 3'd1,
    ST_PLL  = 3'd2,
    ST_HAND = 3'd3,
    ST_PRI  = 3'd4
  } clksw_state_e;

  function automatic logic src_is_internal(input logic [1:0] code);
    return code[1];
  endfunction
endpackage

// File: rtl/clksw_cfg_reg.sv
module clksw_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wr_src,
  input  logic       wr_idle,
  output logic [1:0] src_q,
  output logic       idle_q,
  output logic       src_change
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= 2'b00;
      idle_q <= 1'b0;
    end else if (wr) begin
      src_q  <= wr_src;
      idle_q <= wr_idle;
    end
  end

  assign src_change = wr && (wr_src != src_q);

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable({src_q, idle_q}));
endmodule

// File: rtl/clksw_timer.sv
module clksw_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = inc && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || done) cnt <= '0;
    else if (inc)              cnt <= cnt + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_change,
  input  logic         new_internal,
  input  logic         ost_done,
  input  logic         pll_done,
  input  logic         pll_en,
  input  logic         int_tick,
  output clksw_state_e state
);
  clksw_state_e nxt;

  always_comb begin
    nxt = state;
    if (src_change && new_internal) begin
      nxt = ST_INT;
    end else if (src_change && state != ST_PRI) begin
      nxt = ST_OST;
    end else begin
      unique case (state)
        ST_OST:  if (ost_done) nxt = pll_en ? ST_PLL : ST_HAND;
        ST_PLL:  if (pll_done) nxt = ST_HAND;
        ST_HAND: if (int_tick) nxt = ST_PRI;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OST;
    else        state <= nxt;
  end

  // R5
  handover_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRI && $past(state) != ST_PRI) |-> $past(int_tick));
  // R5
  handover_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRI && $past(state) != ST_PRI) |-> $past(state) == ST_HAND);
  // R4
  pll_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLL) |-> pll_en || $past(state) == ST_PLL);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_src,
  input  logic       cfg_idle,
  input  logic       pll_en,
  input  logic       wdt_en,
  input  logic       fscm_en,
  input  logic       int_tick,
  input  logic       prim_tick,
  output logic [1:0] src_sel,
  output logic       idle_en,
  output logic       prim_osc_en,
  output logic       int_osc_en,
  output logic       sel_internal,
  output logic       osc_ready,
  output logic       sys_ce
);
  clksw_state_e state;
  logic src_change, ost_done, pll_done, prim_q;

  clksw_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_src(cfg_src), .wr_idle(cfg_idle),
    .src_q(src_sel), .idle_q(idle_en), .src_change(src_change)
  );

  assign prim_q = prim_tick && prim_osc_en;

  clksw_timer #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_OST || src_change),
    .inc(state == ST_OST && prim_q),
    .done(ost_done)
  );

  clksw_timer #(.LIMIT(PLL_TICKS)) u_pll (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_PLL || src_change),
    .inc(state == ST_PLL && int_tick),
    .done(pll_done)
  );

  clksw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .src_change(src_change),
    .new_internal(src_is_internal(cfg_src)),
    .ost_done(ost_done), .pll_done(pll_done), .pll_en(pll_en),
    .int_tick(int_tick), .state(state)
  );

  assign prim_osc_en  = (state != ST_INT);
  assign sel_internal = (state != ST_PRI);
  assign osc_ready    = (state == ST_PRI);
  assign int_osc_en   = sel_internal || wdt_en || fscm_en;
  assign sys_ce       = sel_internal ? int_tick : prim_q;

  // R2
  prim_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel[1] |-> !prim_osc_en && sel_internal);
  // R7
  int_osc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_ready |-> int_osc_en);
  // R10
  ce_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce |-> (int_tick || prim_tick));
  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_ready) |-> $past(int_tick) && !src_sel[1]);
endmodule

// File: tb/tb_clksw_ctrl.sv
`timescale 1ns/1ps
module tb_clksw_ctrl;
  localparam int OSTN = 16;
  localparam int PLLN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_idle = 1'b0;
  logic [1:0] cfg_src = 2'b00;
  logic pll_en = 1'b0, wdt_en = 1'b0, fscm_en = 1'b0;
  logic int_tick = 1'b0, prim_tick = 1'b0;
  logic [1:0] src_sel;
  logic idle_en, prim_osc_en, int_osc_en, sel_internal, osc_ready, sys_ce;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // bench-side model: 0 internal, 1 counting, 2 pll, 3 waiting, 4 primary
  int m_ph, m_cnt;
  logic [1:0] m_src;
  logic m_idle;
  int k;

  always #4 clk = ~clk;

  clksw_ctrl #(.OST_CYCLES(OSTN), .PLL_TICKS(PLLN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_idle(cfg_idle),
    .pll_en(pll_en), .wdt_en(wdt_en), .fscm_en(fscm_en),
    .int_tick(int_tick), .prim_tick(prim_tick),
    .src_sel(src_sel), .idle_en(idle_en), .prim_osc_en(prim_osc_en),
    .int_osc_en(int_osc_en), .sel_internal(sel_internal), .osc_ready(osc_ready),
    .sys_ce(sys_ce)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 1'b0; int_tick = 1'b0; prim_tick = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    m_ph = 1; m_cnt = 0; m_src = 2'b00; m_idle = 1'b0; k = 0;
    // R1
    chk("R1 src_sel", src_sel, 2'b00);
    chk("R1 idle_en", {1'b0, idle_en}, 2'b00);
    chk("R1 osc_ready", {1'b0, osc_ready}, 2'b00);
    chk("R1 sel_internal", {1'b0, sel_internal}, 2'b01);
    chk("R1 prim_osc_en", {1'b0, prim_osc_en}, 2'b01);
    chk("R1 int_osc_en", {1'b0, int_osc_en}, 2'b01);
  endtask

  // one fabric cycle with given pulses and optional write
  task automatic step(input logic it, input logic pt, input logic wr,
                      input logic [1:0] src, input logic idl);
    logic e_int, e_pen, e_rdy, e_ce, e_ien, chg;
    int_tick = it; prim_tick = pt; cfg_wr = wr; cfg_src = src; cfg_idle = idl;
    #1;
    e_int = (m_ph != 4);
    e_rdy = (m_ph == 4);
    e_pen = (m_ph != 0);
    e_ien = e_int | wdt_en | fscm_en;
    e_ce  = e_int ? it : (pt & e_pen);
    chk("R3/R5 sel_internal", {1'b0, sel_internal}, {1'b0, e_int});
    chk("R3/R5 osc_ready", {1'b0, osc_ready}, {1'b0, e_rdy});
    chk("R2 prim_osc_en", {1'b0, prim_osc_en}, {1'b0, e_pen});
    chk("R7 int_osc_en", {1'b0, int_osc_en}, {1'b0, e_ien});
    chk("R10 sys_ce", {1'b0, sys_ce}, {1'b0, e_ce});
    chk("R6 src_sel", src_sel, m_src);
    chk("R6 idle_en", {1'b0, idle_en}, {1'b0, m_idle});
    // next state from the requirements (R2, R3, R4, R5, R8, R9)
    chg = wr && (src != m_src);
    if (chg && src[1]) begin m_ph = 0; m_cnt = 0; end
    else if (chg && m_ph != 4) begin m_ph = 1; m_cnt = 0; end
    else begin
      case (m_ph)
        1: if (pt) begin
             if (m_cnt == OSTN - 1) begin m_ph = pll_en ? 2 : 3; m_cnt = 0; end
             else m_cnt++;
           end
        2: if (it) begin
             if (m_cnt == PLLN - 1) begin m_ph = 3; m_cnt = 0; end
             else m_cnt++;
           end
        3: if (it) m_ph = 4;
        default: ;
      endcase
    end
    if (wr) begin m_src = src; m_idle = idl; end
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    k++;
  endtask

  task automatic run(input int n, input int ip, input int pp);
    for (int i = 0; i < n; i++)
      step((k % ip) == 0, ((k + 1) % pp) == 0, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic wr_src(input logic [1:0] v, input logic idl, input int ip, input int pp);
    step((k % ip) == 0, ((k + 1) % pp) == 0, 1'b1, v, idl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2;
    do_reset();
    // R3 R4 R5: full sweep of pulse spacings and PLL use
    for (int pl = 0; pl < 2; pl++)
      for (int ip = 1; ip <= 3; ip++)
        for (int pp = 1; pp <= 3; pp++) begin
          pll_en = pl[0];
          do_reset();
          run(OSTN * 3 + PLLN * 3 + 12, ip, pp);
          chk("R5 ready after sweep", {1'b0, osc_ready}, 2'b01);
          // R9: primary to primary rewrite while running
          wr_src(2'b01, 1'b1, ip, pp);
          run(6, ip, pp);
          // R2: go internal
          wr_src(2'b11, 1'b0, ip, pp);
          run(8, ip, pp);
          chk("R2 off after write", {1'b0, prim_osc_en}, 2'b00);
          // R9: internal to internal rewrite
          wr_src(2'b10, 1'b1, ip, pp);
          run(4, ip, pp);
          // R8: back to primary, restart mid count, then abort
          wr_src(2'b00, 1'b0, ip, pp);
          run(OSTN, ip, pp);
          wr_src(2'b01, 1'b0, ip, pp);
          run(OSTN * 2, ip, pp);
          wr_src(2'b11, 1'b0, ip, pp);
          run(5, ip, pp);
          chk("R8 abort to internal", {1'b0, sel_internal}, 2'b01);
          // R6: same-value write still updates idle only
          wr_src(2'b11, 1'b1, ip, pp);
          run(3, ip, pp);
          wr_src(2'b00, 1'b0, ip, pp);
          run(OSTN * 3 + PLLN * 3 + 12, ip, pp);
        end
    // R7: keep-alive sweep while on primary
    pll_en = 1'b0;
    do_reset();
    run(OSTN + 6, 1, 1);
    for (int w = 0; w < 4; w++) begin
      wdt_en = w[0]; fscm_en = w[1];
      run(3, 2, 1);
      chk("R7 keep-alive", {1'b0, int_osc_en}, {1'b0, (w != 0)});
    end
    wdt_en = 1'b0; fscm_en = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule